// File: doc/BRIEF.md
# Dataflow Actor Firing Controller

This block decides when the synchronous-dataflow actors mapped onto one processing element may fire. Every edge of the actor graph has a token counter and a free-space counter. An actor is eligible only when each of its input edges holds at least the number of tokens it consumes per firing, and each of its output edges has room for the tokens it produces. An actor also needs a free concurrency slot. The graph shape, the rates, the edge capacities, the preloaded tokens, the execution times and the concurrency limits are all elaboration-time parameters.

In each cycle the controller grants at most one eligible actor. It takes the consumed tokens and the reserved space away from the counters and starts a firing. The firing cannot be interrupted. It lasts exactly the actor's worst-case execution time in cycles. When it ends, the produced tokens are added to the output edges and the consumed space is given back to the input edges. The concurrency limit works like a self-edge that holds K tokens: a firing takes a slot when it starts and frees it when it ends.

Edges that connect to neighbouring tiles are updated through a valid/ready port. A fill puts tokens onto an edge that is fed from outside. A drain takes tokens off an edge that leaves the tile. A request that does not fit keeps `upd_ready` low, and the sender must hold its request until it fits. A request whose direction does not suit the edge is accepted and dropped.

Top module: `dfc_fire_ctrl`

## Requirements
- R1: During and right after reset, `start_vec`, `done_vec` and `busy` are zero. Each edge's token count equals its preload, and each edge's free space equals its capacity minus its preload.
- R2: An actor starts only if every input edge has tokens >= its consumption rate, every output edge has space >= its production rate, and it has a free slot. Tokens plus space on an edge never exceed its capacity.
- R3: Preloaded tokens take effect from reset. In the default graph, edge 2 holds 3 tokens, so actor 2 starts in the first cycle after reset.
- R4: At most one actor starts per cycle. When several actors are eligible, the one with the lowest index starts. Bit a of `start_vec` is high for the one cycle after the grant edge.
- R5: No actor has more than K firings in flight, where K is its slot count (default K = 1, 2, 1 for actors 0, 1, 2).
- R6: A firing is non-preemptive. Bit a of `done_vec` pulses exactly W cycles after the matching `start_vec` pulse, where W is the actor's execution time (default W = 3, 2, 4).
- R7: In the cycle a firing starts, the consumption rate is subtracted from each input edge's tokens and the production rate from each output edge's space. In the cycle it completes, tokens are added to its output edges and space is returned to its input edges. All events in the same cycle, including external updates, are summed.
- R8: With `upd_drain` = 0 (fill), an accepted request adds `upd_amt` tokens to an externally fed edge and removes that much space. With `upd_drain` = 1 (drain), it removes tokens from an externally consumed edge and returns the space. `upd_ready` is low only when a correctly directed request is larger than the available space (fill) or tokens (drain). A wrongly directed request is accepted and leaves every counter unchanged.
- R9: `deadlock` is high exactly when no firing is in flight and no actor is eligible.
- R10: Asymmetric rates enable several firings at once. In the default graph, one actor-0 firing produces 6 tokens on edge 1, and actor 1 (rate 2) then fires 3 times.

Default graph (edge: producer -> consumer, production/consumption rate, capacity, preload): edge 0: outside -> actor 0, -/1, 4, 0; edge 1: actor 0 -> actor 1, 6/2, 8, 0; edge 2: actor 1 -> actor 2, 1/3, 4, 3; edge 3: actor 2 -> outside, 1/-, 2, 0. Edge c occupies bits [c*CNT_W +: CNT_W] of `chan_tok` and `chan_spc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_valid | input | 1 | External counter update is offered |
| upd_ready | output | 1 | Update accepted this cycle |
| upd_chan | input | CH_W (2) | Edge index of the update |
| upd_drain | input | 1 | 0 = fill (tokens arrive), 1 = drain (tokens leave) |
| upd_amt | input | CNT_W (8) | Number of tokens in the update |
| start_vec | output | N_ACT (3) | One-cycle firing start pulse per actor |
| done_vec | output | N_ACT (3) | One-cycle firing completion pulse per actor |
| busy | output | 1 | At least one firing in flight |
| deadlock | output | 1 | Nothing in flight and nothing eligible |
| chan_tok | output | N_CH*CNT_W (32) | Token count per edge |
| chan_spc | output | N_CH*CNT_W (32) | Free space per edge |

## Verification
Any wrong counter delta appears on `chan_tok` or `chan_spc` in the cycle after the edge that applied it. It then changes which actor is eligible, so `start_vec` diverges within one firing duration. Errors in timers or slots show up as a `done_vec` pulse at the wrong distance from its start, or as an extra start while all of an actor's slots are occupied. The bench runs a cycle-by-cycle reference of the rules and compares every output in every cycle, so a fault is reported in the cycle it first becomes visible.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  // Marks an edge end that lies outside this tile.
  localparam int DFC_EXT = -1;

  typedef enum logic {
    DFC_FILL  = 1'b0,
    DFC_DRAIN = 1'b1
  } dfc_upd_e;
endpackage

// File: rtl/dfc_prio_pick.sv
// Fixed-priority picker: the lowest set request bit wins.
module dfc_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any_req
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign gnt[i]      = req[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | req[i];
  end

  assign any_req = seen[N];
endmodule

// File: rtl/dfc_actor_slots.sv
// Concurrency slots of one actor; each slot is a cycle countdown of one firing.
module dfc_actor_slots #(
  parameter int K     = 1,
  parameter int MAX_K = 2,
  parameter int WCET  = 3,
  parameter int T_W   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic free,
  output logic fin,
  output logic busy
);
  logic [T_W-1:0]   tim [MAX_K];
  logic [MAX_K-1:0] idle, occ, last, pick;

  dfc_prio_pick #(.N(MAX_K)) u_pick (
    .req    (idle),
    .gnt    (pick),
    .any_req(free)
  );

  for (genvar s = 0; s < MAX_K; s++) begin : g_slot
    if (s < K) begin : g_live
      assign idle[s] = (tim[s] == '0);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                tim[s] <= '0;
        else if (go && pick[s])    tim[s] <= T_W'(WCET);
        else if (tim[s] != '0)     tim[s] <= tim[s] - T_W'(1);
      end
    end else begin : g_dead
      assign idle[s] = 1'b0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tim[s] <= '0;
        else        tim[s] <= '0;
      end
    end
    assign occ[s]  = (tim[s] != '0);
    assign last[s] = (tim[s] == T_W'(1));

    // R6: a running firing counts down every cycle and cannot be cut short
    p_nonpreempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tim[s] != '0) |=> (tim[s] == $past(tim[s]) - T_W'(1)));
  end

  assign fin  = |last;
  assign busy = |occ;

  // R5: in-flight firings never exceed the self-edge token count
  p_self_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ) <= K);
  // R5: a grant only arrives when a slot is free
  p_go_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> free);
endmodule

// File: rtl/dfc_chan_ctr.sv
// Token and free-space counters of one edge with all same-cycle deltas merged.
module dfc_chan_ctr #(
  parameter int CNT_W = 8,
  parameter int CAP   = 4,
  parameter int INIT  = 0,
  parameter int PRATE = 1,
  parameter int CRATE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_go,
  input  logic             src_fin,
  input  logic             dst_go,
  input  logic             dst_fin,
  input  logic             fill_en,
  input  logic             drain_en,
  input  logic [CNT_W-1:0] amt,
  output logic [CNT_W-1:0] tok,
  output logic [CNT_W-1:0] spc
);
  localparam int SW = CNT_W + 2;
  localparam logic [SW-1:0] P_W   = SW'(PRATE);
  localparam logic [SW-1:0] C_W   = SW'(CRATE);
  localparam logic [SW-1:0] CAP_W = SW'(CAP);

  logic [SW-1:0] amt_w, t_up, t_dn, s_up, s_dn;

  assign amt_w = {2'b00, amt};
  assign t_up  = {2'b00, tok} + (src_fin ? P_W : '0) + (fill_en  ? amt_w : '0);
  assign t_dn  = (dst_go  ? C_W : '0) + (drain_en ? amt_w : '0);
  assign s_up  = {2'b00, spc} + (dst_fin ? C_W : '0) + (drain_en ? amt_w : '0);
  assign s_dn  = (src_go  ? P_W : '0) + (fill_en  ? amt_w : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok <= CNT_W'(INIT);
      spc <= CNT_W'(CAP - INIT);
    end else begin
      tok <= CNT_W'(t_up - t_dn);
      spc <= CNT_W'(s_up - s_dn);
    end
  end

  // R7: merged deltas never take a counter below zero
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (t_up >= t_dn) && (s_up >= s_dn));
  // R2: tokens plus space stay within the capacity
  p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ({2'b00, tok} + {2'b00, spc}) <= CAP_W);
  // R8: an accepted external update always fits
  p_fill_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> (spc >= amt));
  p_drain_tok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drain_en |-> (tok >= amt));
endmodule

// File: rtl/dfc_fire_ctrl.sv
module dfc_fire_ctrl
  import dfc_pkg::*;
#(
  parameter int N_ACT = 3,
  parameter int N_CH  = 4,
  parameter int CNT_W = 8,
  parameter int T_W   = 8,
  parameter int MAX_K = 2,
  parameter int CH_SRC   [N_CH]  = '{DFC_EXT, 0, 1, 2},
  parameter int CH_DST   [N_CH]  = '{0, 1, 2, DFC_EXT},
  parameter int CH_PRATE [N_CH]  = '{1, 6, 1, 1},
  parameter int CH_CRATE [N_CH]  = '{1, 2, 3, 1},
  parameter int CH_CAP   [N_CH]  = '{4, 8, 4, 2},
  parameter int CH_INIT  [N_CH]  = '{0, 0, 3, 0},
  parameter int ACT_WCET [N_ACT] = '{3, 2, 4},
  parameter int ACT_K    [N_ACT] = '{1, 2, 1},
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd_valid,
  output logic                   upd_ready,
  input  logic [CH_W-1:0]        upd_chan,
  input  logic                   upd_drain,
  input  logic [CNT_W-1:0]       upd_amt,
  output logic [N_ACT-1:0]       start_vec,
  output logic [N_ACT-1:0]       done_vec,
  output logic                   busy,
  output logic                   deadlock,
  output logic [N_CH*CNT_W-1:0]  chan_tok,
  output logic [N_CH*CNT_W-1:0]  chan_spc
);
  dfc_upd_e kind;
  assign kind = dfc_upd_e'(upd_drain);

  logic [N_ACT-1:0] free, fin, act_busy, ready, gnt;
  logic             any_ready;
  logic [N_ACT-1:0][N_CH-1:0] blk;
  logic [CNT_W-1:0] tok [N_CH];
  logic [CNT_W-1:0] spc [N_CH];
  logic [N_CH-1:0]  fill_en, drain_en;
  logic             upd_legal, upd_fit;

  // External update: decide direction legality and whether it fits.
  always_comb begin
    upd_legal = 1'b0;
    upd_fit   = 1'b0;
    for (int c = 0; c < N_CH; c++) begin
      if (upd_chan == CH_W'(c)) begin
        if (kind == DFC_FILL && CH_SRC[c] < 0) begin
          upd_legal = 1'b1;
          upd_fit   = (spc[c] >= upd_amt);
        end else if (kind == DFC_DRAIN && CH_DST[c] < 0) begin
          upd_legal = 1'b1;
          upd_fit   = (tok[c] >= upd_amt);
        end
      end
    end
  end
  assign upd_ready = !upd_legal || upd_fit;

  // Per-actor slots and eligibility.
  for (genvar a = 0; a < N_ACT; a++) begin : g_act
    dfc_actor_slots #(
      .K    (ACT_K[a]),
      .MAX_K(MAX_K),
      .WCET (ACT_WCET[a]),
      .T_W  (T_W)
    ) u_slots (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (gnt[a]),
      .free (free[a]),
      .fin  (fin[a]),
      .busy (act_busy[a])
    );
    assign ready[a] = free[a] & ~(|blk[a]);
  end

  dfc_prio_pick #(.N(N_ACT)) u_pick (
    .req    (ready),
    .gnt    (gnt),
    .any_req(any_ready)
  );

  // Per-edge counters.
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic src_go, src_fin, dst_go, dst_fin;

    if (CH_SRC[c] >= 0) begin : g_src
      assign src_go  = gnt[CH_SRC[c]];
      assign src_fin = fin[CH_SRC[c]];
    end else begin : g_xsrc
      assign src_go  = 1'b0;
      assign src_fin = 1'b0;
    end

    if (CH_DST[c] >= 0) begin : g_dst
      assign dst_go  = gnt[CH_DST[c]];
      assign dst_fin = fin[CH_DST[c]];
    end else begin : g_xdst
      assign dst_go  = 1'b0;
      assign dst_fin = 1'b0;
    end

    for (genvar a = 0; a < N_ACT; a++) begin : g_blk
      assign blk[a][c] = ((CH_DST[c] == a) && (tok[c] < CNT_W'(CH_CRATE[c]))) ||
                         ((CH_SRC[c] == a) && (spc[c] < CNT_W'(CH_PRATE[c])));
    end

    assign fill_en[c]  = upd_valid && upd_fit && (kind == DFC_FILL)  &&
                         (CH_SRC[c] < 0) && (upd_chan == CH_W'(c));
    assign drain_en[c] = upd_valid && upd_fit && (kind == DFC_DRAIN) &&
                         (CH_DST[c] < 0) && (upd_chan == CH_W'(c));

    dfc_chan_ctr #(
      .CNT_W(CNT_W),
      .CAP  (CH_CAP[c]),
      .INIT (CH_INIT[c]),
      .PRATE(CH_PRATE[c]),
      .CRATE(CH_CRATE[c])
    ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_go  (src_go),
      .src_fin (src_fin),
      .dst_go  (dst_go),
      .dst_fin (dst_fin),
      .fill_en (fill_en[c]),
      .drain_en(drain_en[c]),
      .amt     (upd_amt),
      .tok     (tok[c]),
      .spc     (spc[c])
    );

    assign chan_tok[c*CNT_W +: CNT_W] = tok[c];
    assign chan_spc[c*CNT_W +: CNT_W] = spc[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_vec <= '0;
      done_vec  <= '0;
    end else begin
      start_vec <= gnt;
      done_vec  <= fin;
    end
  end

  assign busy     = |act_busy;
  assign deadlock = ~busy & ~any_ready;

  // R4: one start per cycle at most
  p_one_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_vec));
  // R9: a deadlocked cycle is followed by a cycle without a start
  p_deadlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> (start_vec == '0));
  // R8: a held request is a correctly directed one
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_ready) |-> upd_legal);
endmodule

// File: tb/sim_dfc_fire_ctrl.sv
module sim_dfc_fire_ctrl;
  localparam int NA = 3;
  localparam int NC = 4;
  localparam int SRC [NC] = '{-1, 0, 1, 2};
  localparam int DST [NC] = '{0, 1, 2, -1};
  localparam int PR  [NC] = '{1, 6, 1, 1};
  localparam int CR  [NC] = '{1, 2, 3, 1};
  localparam int CAP [NC] = '{4, 8, 4, 2};
  localparam int INI [NC] = '{0, 0, 3, 0};
  localparam int WC  [NA] = '{3, 2, 4};
  localparam int KK  [NA] = '{1, 2, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [1:0]  upd_chan = '0;
  logic        upd_drain = 1'b0;
  logic [7:0]  upd_amt = '0;
  logic [2:0]  start_vec, done_vec;
  logic        busy, deadlock;
  logic [31:0] chan_tok, chan_spc;

  dfc_fire_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_chan(upd_chan),
    .upd_drain(upd_drain), .upd_amt(upd_amt),
    .start_vec(start_vec), .done_vec(done_vec), .busy(busy), .deadlock(deadlock),
    .chan_tok(chan_tok), .chan_spc(chan_spc)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit ended = 1'b0;

  int m_tok [NC];
  int m_spc [NC];
  int m_tim [NA][2];
  int infl  [NA];
  logic [2:0] m_start, m_done;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit m_ready(int a);
    bit fr = 1'b0;
    for (int s = 0; s < KK[a]; s++) if (m_tim[a][s] == 0) fr = 1'b1;
    for (int c = 0; c < NC; c++) begin
      if (DST[c] == a && m_tok[c] < CR[c]) fr = 1'b0;
      if (SRC[c] == a && m_spc[c] < PR[c]) fr = 1'b0;
    end
    return fr;
  endfunction

  function automatic int m_pick();
    for (int a = 0; a < NA; a++) if (m_ready(a)) return a;
    return -1;
  endfunction

  function automatic bit m_legal(int ch, bit dr);
    return dr ? (DST[ch] < 0) : (SRC[ch] < 0);
  endfunction

  function automatic bit m_fit(int ch, bit dr, int amt);
    return dr ? (m_tok[ch] >= amt) : (m_spc[ch] >= amt);
  endfunction

  function automatic bit m_busy();
    for (int a = 0; a < NA; a++)
      for (int s = 0; s < 2; s++) if (m_tim[a][s] != 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic m_reset();
    for (int c = 0; c < NC; c++) begin
      m_tok[c] = INI[c];
      m_spc[c] = CAP[c] - INI[c];
    end
    for (int a = 0; a < NA; a++) begin
      infl[a] = 0;
      for (int s = 0; s < 2; s++) m_tim[a][s] = 0;
    end
    m_start = '0;
    m_done  = '0;
  endtask

  task automatic m_step(bit v, int ch, bit dr, int amt);
    int g;
    bit [2:0] fn;
    bit acc;
    int ot [NA][2];
    g = m_pick();
    fn = '0;
    for (int a = 0; a < NA; a++)
      for (int s = 0; s < KK[a]; s++) if (m_tim[a][s] == 1) fn[a] = 1'b1;
    acc = v && m_legal(ch, dr) && m_fit(ch, dr, amt);
    for (int c = 0; c < NC; c++) begin
      if (SRC[c] >= 0) begin
        if (fn[SRC[c]]) m_tok[c] += PR[c];
        if (g == SRC[c]) m_spc[c] -= PR[c];
      end
      if (DST[c] >= 0) begin
        if (g == DST[c]) m_tok[c] -= CR[c];
        if (fn[DST[c]]) m_spc[c] += CR[c];
      end
      if (acc && ch == c) begin
        if (!dr) begin m_tok[c] += amt; m_spc[c] -= amt; end
        else     begin m_tok[c] -= amt; m_spc[c] += amt; end
      end
    end
    ot = m_tim;
    for (int a = 0; a < NA; a++)
      for (int s = 0; s < KK[a]; s++) if (ot[a][s] != 0) m_tim[a][s] = ot[a][s] - 1;
    if (g >= 0) begin
      for (int s = 0; s < KK[g]; s++) begin
        if (ot[g][s] == 0) begin
          m_tim[g][s] = WC[g];
          break;
        end
      end
    end
    m_start = (g >= 0) ? 3'(1 << g) : 3'b000;
    m_done  = fn;
  endtask

  task automatic compare();
    chk("R4", "start_vec", int'(start_vec), int'(m_start));
    chk("R6", "done_vec", int'(done_vec), int'(m_done));
    for (int c = 0; c < NC; c++) begin
      chk("R7", $sformatf("tok[%0d]", c), int'(chan_tok[c*8 +: 8]), m_tok[c]);
      chk("R7", $sformatf("spc[%0d]", c), int'(chan_spc[c*8 +: 8]), m_spc[c]);
    end
    chk("R9", "deadlock", int'(deadlock), int'(!m_busy() && m_pick() < 0));
    chk("R6", "busy", int'(busy), int'(m_busy()));
    for (int a = 0; a < NA; a++) begin
      infl[a] += int'(start_vec[a]) - int'(done_vec[a]);
      if (start_vec[a]) chk("R5", $sformatf("inflight[%0d]<=K", a), int'(infl[a] <= KK[a]), 1);
    end
  endtask

  // Called at a falling edge: drive, check ready, advance one clock, compare.
  task automatic cycle(bit v, int ch, bit dr, int amt);
    upd_valid = v;
    upd_chan  = 2'(ch);
    upd_drain = dr;
    upd_amt   = 8'(amt);
    #1;
    if (v) chk("R8", "upd_ready", int'(upd_ready),
               int'(!m_legal(ch, dr) || m_fit(ch, dr, amt)));
    @(posedge clk);
    @(negedge clk);
    m_step(v, ch, dr, amt);
    compare();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !ended) begin
      ended = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    int a1_starts;
    seed_init = $urandom(32'd20240611);
    m_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "start_vec", int'(start_vec), 0);
    chk("R1", "done_vec", int'(done_vec), 0);
    chk("R1", "busy", int'(busy), 0);
    for (int c = 0; c < NC; c++) begin
      chk("R1", $sformatf("tok[%0d]", c), int'(chan_tok[c*8 +: 8]), INI[c]);
      chk("R1", $sformatf("spc[%0d]", c), int'(chan_spc[c*8 +: 8]), CAP[c] - INI[c]);
    end
    chk("R9", "deadlock with actor 2 eligible", int'(deadlock), 0);
    rst_n = 1'b1;

    // R3: preloaded edge 2 lets actor 2 start at once
    cycle(0, 0, 0, 0);
    chk("R3", "first start is actor 2", int'(start_vec), 4);
    chk("R7", "edge 2 tokens taken at start", int'(chan_tok[16 +: 8]), 0);
    for (int i = 0; i < 8; i++) cycle(0, 0, 0, 0);
    chk("R9", "deadlock after lone firing", int'(deadlock), 1);
    chk("R7", "edge 3 token produced", int'(chan_tok[24 +: 8]), 1);

    // R8: wrongly directed requests are dropped, oversized fill is held
    cycle(1, 0, 1, 3);
    chk("R8", "drain on input edge ignored", int'(chan_tok[0 +: 8]), 0);
    cycle(1, 1, 0, 2);
    chk("R8", "fill on inner edge ignored", int'(chan_tok[8 +: 8]), 0);
    upd_valid = 1'b1; upd_chan = 2'd0; upd_drain = 1'b0; upd_amt = 8'd5;
    #1;
    chk("R8", "oversized fill held", int'(upd_ready), 0);
    cycle(1, 0, 0, 5);
    chk("R2", "no start while input edge empty", int'(start_vec), 0);

    // R10: one actor-0 firing feeds three actor-1 firings
    cycle(1, 0, 0, 1);
    a1_starts = 0;
    for (int i = 0; i < 20; i++) begin
      cycle(0, 0, 0, 0);
      if (start_vec[1]) a1_starts++;
    end
    chk("R10", "actor-1 starts per actor-0 firing", a1_starts, 3);

    // Random traffic on the external edges
    for (int i = 0; i < 3000; i++) begin
      cycle(($urandom % 2) == 0, int'($urandom % NC), ($urandom % 2) == 1,
            int'($urandom % 6));
    end
    // Drain edge 3 and refill edge 0 to push tie cases through the arbiter
    for (int i = 0; i < 200; i++) begin
      cycle(1, (i % 2 == 0) ? 3 : 0, (i % 2 == 0), 1);
    end

    ended = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule